// File: doc/BRIEF.md
# SAR Conversion Sequencer

This block is the digital controller of a 12-bit successive-approximation converter. It accepts a conversion request and opens the sampling switch for two clock cycles. It then resolves one result bit per clock, from the most significant bit down. In each decision cycle it proposes a trial DAC code and fires the comparator. The comparator evaluates on the falling clock edge, and the block captures its decision on the next rising edge. When the search is complete, the block copies the code into a result register and pulses a done strobe.

Every conversion occupies a fixed frame of 16 clocks: 2 sampling cycles, 12 decision cycles, one spare cycle and one transfer cycle. If the request input is held high, frames follow one another with no gap. A single-ended mode fixes the top bit at zero and searches only the lower 11 bits. An enable input aborts any conversion while it is low and keeps the block idle.

Top module: `sar_seq`

## Requirements
- R1: While `rst` is high, and on the first cycle after it is released, `sample_on`, `cmp_fire` and `done` are 0, and `dac_code` and `result` are 0.
- R2: A conversion is accepted only on a rising edge where the block is idle (or in the last cycle of its frame), `enable` is 1 and `start` is 1. A `start` pulse during a conversion has no effect on that conversion or on the frames that follow.
- R3: `sample_on` is high for exactly the two cycles that follow the accepting edge. It is never high at the same time as `cmp_fire`.
- R4: In differential mode, `cmp_fire` is high for the 12 cycles that follow sampling. In each of those cycles, `dac_code` holds the bits already decided plus a trial 1 in the current bit. `cmp_hi` = 1 means the input is at or above the DAC level, and the bit is then kept; `cmp_hi` = 0 clears it.
- R5: With an ideal comparator, `result` equals the input code. All 12 bits are decided MSB first.
- R6: `done` is a one-cycle pulse that becomes visible 16 clock edges after the accepting edge. `result` changes only in a cycle where `done` is high.
- R7: While `start` stays high, the next sampling phase begins in the cycle in which `done` is seen, so results arrive every 16 clocks.
- R8: `single_ended` is captured on the accepting edge and ignored afterwards. When it was 1, bit 11 of `dac_code` and of `result` is 0, `cmp_fire` is high for 11 cycles, and `result` equals min(input, 2047).
- R9: While `enable` is 0, the running conversion is abandoned, `start` is ignored, `sample_on`, `cmp_fire` and `done` stay 0, and `result` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; comparator evaluates on falling edge, decisions taken on rising edge |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Block runs when 1; held idle when 0 |
| start | input | 1 | Conversion request |
| single_ended | input | 1 | 1 selects the 11-bit single-ended search |
| cmp_hi | input | 1 | Comparator decision: 1 when input is at or above DAC level |
| sample_on | output | 1 | Sampling switch control |
| cmp_fire | output | 1 | Comparator trigger for the current decision cycle |
| dac_code | output | 12 | Trial code applied to the DAC |
| done | output | 1 | One-cycle pulse when `result` updates |
| result | output | 12 | Last completed conversion word |

## Verification
The assertions assume that `cmp_hi` is a settled level by each rising edge, and that `start`, `enable` and `single_ended` change only between edges. The bench drives every input and its comparator model on the falling edge, so this assumption holds. The comparator model answers only when `cmp_fire` is high and compares a held input code against `dac_code`. Because of this, the bench can predict each result from the input code alone. The input code is changed only outside decision cycles, or between frames, so each conversion sees one steady value.

// File: rtl/sar_pkg.sv
package sar_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SAMPLE,
        PH_DECIDE,
        PH_SPARE,
        PH_XFER
    } phase_e;

    // Maps a frame slot to its phase for a given frame layout.
    function automatic phase_e slot_phase(
        input logic busy,
        input int   slot,
        input int   n_sample,
        input int   n_bits,
        input int   n_frame
    );
        if (!busy)                       return PH_IDLE;
        if (slot < n_sample)             return PH_SAMPLE;
        if (slot < n_sample + n_bits)    return PH_DECIDE;
        if (slot == n_frame - 1)         return PH_XFER;
        return PH_SPARE;
    endfunction

endpackage

// File: rtl/sar_frame_ctr.sv
module sar_frame_ctr
    import sar_pkg::*;
#(
    parameter int SAMPLE_CYC = 2,
    parameter int RES_W      = 12,
    parameter int FRAME_CYC  = 16,
    localparam int SLOT_W    = $clog2(FRAME_CYC)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              start,
    input  logic              single_ended,
    output logic [SLOT_W-1:0] slot,
    output logic              se_q,
    output phase_e            phase
);

    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(FRAME_CYC - 1);

    logic busy;

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            busy <= 1'b0;
            slot <= '0;
            se_q <= 1'b0;
        end else if (!busy) begin
            if (start) begin
                busy <= 1'b1;
                slot <= '0;
                se_q <= single_ended;
            end
        end else if (slot == LAST_SLOT) begin
            slot <= '0;
            if (start) begin
                se_q <= single_ended;
            end else begin
                busy <= 1'b0;
            end
        end else begin
            slot <= slot + 1'b1;
        end
    end

    always_comb begin
        phase = slot_phase(busy, int'(slot), SAMPLE_CYC, RES_W, FRAME_CYC);
    end

endmodule

// File: rtl/sar_search_reg.sv
module sar_search_reg
    import sar_pkg::*;
#(
    parameter int RES_W      = 12,
    parameter int SAMPLE_CYC = 2,
    parameter int SLOT_W     = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  phase_e            phase,
    input  logic [SLOT_W-1:0] slot,
    input  logic              se_q,
    input  logic              cmp_hi,
    output logic [RES_W-1:0]  code,
    output logic              fire
);

    localparam logic [RES_W-1:0] SEED_DIFF = RES_W'(1) << (RES_W - 1);
    localparam logic [RES_W-1:0] SEED_SE   = RES_W'(1) << (RES_W - 2);

    int               cur_idx;
    logic             load;
    logic [RES_W-1:0] seed;
    logic [RES_W-1:0] nxt;

    always_comb begin
        cur_idx = RES_W - 1 - (int'(slot) - SAMPLE_CYC);
        load    = (phase == PH_SAMPLE) && (slot == SLOT_W'(SAMPLE_CYC - 1));
        seed    = se_q ? SEED_SE : SEED_DIFF;
        // top decision slot is skipped in single-ended mode
        fire    = (phase == PH_DECIDE) && !(se_q && cur_idx == RES_W - 1);
    end

    for (genvar i = 0; i < RES_W; i++) begin : g_bit
        always_comb begin
            nxt[i] = code[i];
            if (load) begin
                nxt[i] = seed[i];
            end else if (fire) begin
                if (cur_idx == i) begin
                    nxt[i] = cmp_hi;
                end else if (cur_idx == i + 1) begin
                    nxt[i] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !enable || phase == PH_IDLE) begin
            code <= '0;
        end else begin
            code <= nxt;
        end
    end

endmodule

// File: rtl/sar_result_reg.sv
module sar_result_reg #(
    parameter int RES_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             xfer,
    input  logic [RES_W-1:0] code,
    output logic [RES_W-1:0] result,
    output logic             done
);

    always_ff @(posedge clk) begin
        if (rst) begin
            result <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (enable && xfer) begin
                result <= code;
                done   <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/sar_seq.sv
module sar_seq
    import sar_pkg::*;
#(
    parameter int RES_W      = 12,
    parameter int SAMPLE_CYC = 2,
    parameter int FRAME_CYC  = 16,
    localparam int SLOT_W    = $clog2(FRAME_CYC)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             start,
    input  logic             single_ended,
    input  logic             cmp_hi,
    output logic             sample_on,
    output logic             cmp_fire,
    output logic [RES_W-1:0] dac_code,
    output logic             done,
    output logic [RES_W-1:0] result
);

    phase_e            phase;
    logic [SLOT_W-1:0] slot;
    logic              se_q;

    sar_frame_ctr #(
        .SAMPLE_CYC (SAMPLE_CYC),
        .RES_W      (RES_W),
        .FRAME_CYC  (FRAME_CYC)
    ) u_frame (
        .clk          (clk),
        .rst          (rst),
        .enable       (enable),
        .start        (start),
        .single_ended (single_ended),
        .slot         (slot),
        .se_q         (se_q),
        .phase        (phase)
    );

    sar_search_reg #(
        .RES_W      (RES_W),
        .SAMPLE_CYC (SAMPLE_CYC),
        .SLOT_W     (SLOT_W)
    ) u_search (
        .clk    (clk),
        .rst    (rst),
        .enable (enable),
        .phase  (phase),
        .slot   (slot),
        .se_q   (se_q),
        .cmp_hi (cmp_hi),
        .code   (dac_code),
        .fire   (cmp_fire)
    );

    sar_result_reg #(
        .RES_W (RES_W)
    ) u_result (
        .clk    (clk),
        .rst    (rst),
        .enable (enable),
        .xfer   (phase == PH_XFER),
        .code   (dac_code),
        .result (result),
        .done   (done)
    );

    assign sample_on = (phase == PH_SAMPLE);

endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
    parameter int RES_W = 12
) (
    input logic             clk,
    input logic             rst,
    input logic             enable,
    input logic             start,
    input logic             sample_on,
    input logic             cmp_fire,
    input logic             done,
    input logic [RES_W-1:0] result,
    input logic [RES_W-1:0] dac_code,
    input logic             se_q
);

    // R2
    accept_gate_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sample_on) |-> ($past(start) && $past(enable)));

    // R3
    sample_fire_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(sample_on && cmp_fire));

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R6
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(result) |-> done);

    // R8
    se_msb_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (se_q && cmp_fire) |-> !dac_code[RES_W-1]);

    // R9
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (!sample_on && !cmp_fire && !done));

endmodule

bind sar_seq sar_seq_chk #(.RES_W(RES_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .enable    (enable),
    .start     (start),
    .sample_on (sample_on),
    .cmp_fire  (cmp_fire),
    .done      (done),
    .result    (result),
    .dac_code  (dac_code),
    .se_q      (se_q)
);

// File: tb/sar_seq_bench.sv
module sar_seq_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable = 1'b1;
    logic        start = 1'b0;
    logic        single_ended = 1'b0;
    logic        cmp_hi = 1'b0;
    logic        sample_on, cmp_fire, done;
    logic [11:0] dac_code, result;
    logic [11:0] vin = 12'd0;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    sar_seq u_sar_seq (
        .clk          (clk),
        .rst          (rst),
        .enable       (enable),
        .start        (start),
        .single_ended (single_ended),
        .cmp_hi       (cmp_hi),
        .sample_on    (sample_on),
        .cmp_fire     (cmp_fire),
        .dac_code     (dac_code),
        .done         (done),
        .result       (result)
    );

    // behavioural comparator: evaluates on the falling edge
    always @(negedge clk) begin
        if (cmp_fire) cmp_hi <= (vin >= dac_code);
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // {single_ended, input code, expected result}
    localparam int NVEC = 10;
    localparam logic [24:0] VEC [NVEC] = '{
        {1'b0, 12'h000, 12'h000},
        {1'b0, 12'hFFF, 12'hFFF},
        {1'b0, 12'h800, 12'h800},
        {1'b0, 12'h7FF, 12'h7FF},
        {1'b0, 12'hA5C, 12'hA5C},
        {1'b1, 12'h3FF, 12'h3FF},
        {1'b1, 12'h7FF, 12'h7FF},
        {1'b1, 12'hFFF, 12'h7FF},
        {1'b1, 12'h800, 12'h7FF},
        {1'b1, 12'h123, 12'h123}
    };

    // launches one conversion and watches it until done
    task automatic run_one(input bit se_i, input logic [11:0] vin_i, input int flip_at,
                           output int lat, output int nsamp, output int nfire,
                           output bit msb_seen, output bit samp_first);
        lat = 0; nsamp = 0; nfire = 0; msb_seen = 0; samp_first = 0;
        @(negedge clk);
        single_ended = se_i;
        vin = vin_i;
        start = 1'b1;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            start = 1'b0;
            lat++;
            if (sample_on) nsamp++;
            if (lat == 1 && sample_on) samp_first = 1;
            if (cmp_fire) nfire++;
            if (cmp_fire && dac_code[11]) msb_seen = 1;
            if (lat == flip_at) single_ended = ~single_ended;
            if (done) break;
        end
    endtask

    initial begin
        #(8 * 200000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int lat, nsamp, nfire, t0, t1, cnt;
        bit msb, sf;

        // R1 reset state
        repeat (3) @(negedge clk);
        check(!sample_on && !cmp_fire && !done, "R1 ctrl", {sample_on, cmp_fire, done}, 0);
        check(dac_code == 0 && result == 0, "R1 data", result, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!sample_on && !done && result == 0, "R1 after release", result, 0);

        // R4 R5 R8: table of conversions
        for (int v = 0; v < NVEC; v++) begin
            bit          se_v;
            logic [11:0] in_v, ex_v;
            {se_v, in_v, ex_v} = VEC[v];
            run_one(se_v, in_v, 0, lat, nsamp, nfire, msb, sf);
            check(result == ex_v, se_v ? "R8 result" : "R5 result", result, ex_v);
            check(lat - 1 == 16, "R6 latency", lat - 1, 16);
            check(nsamp == 2 && sf, "R3 sample window", nsamp, 2);
            check(nfire == (se_v ? 11 : 12), se_v ? "R8 fire count" : "R4 fire count",
                  nfire, se_v ? 11 : 12);
            if (se_v) check(!msb, "R8 msb held low", msb, 0);
            @(negedge clk);
            check(!done, "R6 single pulse", done, 0);
        end

        // R8: mode change mid-conversion ignored
        run_one(1'b1, 12'hFFF, 4, lat, nsamp, nfire, msb, sf);
        check(result == 12'h7FF, "R8 mode latched", result, 12'h7FF);
        single_ended = 1'b0;

        // R7 back-to-back with start held
        @(negedge clk);
        vin = 12'h5A5;
        start = 1'b1;
        t0 = 0; t1 = 0; cnt = 0;
        for (int k = 1; k < 60 && t1 == 0; k++) begin
            @(negedge clk);
            if (done && t0 == 0) begin
                t0 = k;
                check(result == 12'h5A5, "R7 first result", result, 12'h5A5);
                check(sample_on, "R7 next sampling starts", sample_on, 1);
                vin = 12'h1C3;
            end else if (done) begin
                t1 = k;
                check(result == 12'h1C3, "R7 second result", result, 12'h1C3);
                start = 1'b0;
            end
        end
        check(t1 - t0 == 16, "R7 frame period", t1 - t0, 16);
        repeat (20) @(negedge clk);

        // R2 start pulse during conversion ignored
        @(negedge clk);
        vin = 12'h321;
        start = 1'b1;
        nsamp = 0; cnt = 0; lat = 0;
        for (int k = 1; k <= 40; k++) begin
            @(negedge clk);
            start = (k == 5);
            if (sample_on) nsamp++;
            if (done) begin cnt++; lat = k; end
        end
        check(cnt == 1 && lat == 17, "R2 single conversion", cnt, 1);
        check(nsamp == 2, "R2 no extra sampling", nsamp, 2);
        check(result == 12'h321, "R6 result held", result, 12'h321);

        // R9 enable low aborts and blocks start
        @(negedge clk);
        vin = 12'hFFF;
        start = 1'b1;
        cnt = 0;
        for (int k = 1; k <= 12; k++) begin
            @(negedge clk);
            if (k == 6) enable = 1'b0;
            if (k > 6 && (sample_on || cmp_fire || done)) cnt++;
        end
        check(cnt == 0, "R9 quiet while disabled", cnt, 0);
        check(result == 12'h321, "R9 result kept", result, 12'h321);
        enable = 1'b1;
        start = 1'b0;
        cnt = 0;
        for (int k = 1; k <= 25; k++) begin
            @(negedge clk);
            if (done) cnt++;
        end
        check(cnt == 0, "R9 aborted frame gives no done", cnt, 0);
        run_one(1'b0, 12'hFFF, 0, lat, nsamp, nfire, msb, sf);
        check(result == 12'hFFF && lat - 1 == 16, "R9 recovers", result, 12'hFFF);

        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule